// File: doc/BRIEF.md
# Unary ALU with Condition Flags

This block is the single-operand execution stage of a 16-bit processor. It takes one destination operand, an operation code, a byte/word select and the current negative, zero, overflow and carry flags. In the same cycle it returns the new operand value, the new flags, and a store strobe that tells the write-back stage whether the value should be written. It has no state of its own. It sits between operand fetch and write-back, and those stages sequence it.

Each of the fourteen operations has its own flag rule. Some keep the incoming carry, some force it, and some take overflow from fixed boundary operands. The shifts and rotates derive overflow from the new sign and the new carry. In byte mode only the low 8 bits take part. The sign moves to bit 7, the boundary constants shrink to 8 bits, and the upper byte of the operand passes through untouched. Codes with no meaning raise an error output and leave everything as it was.

Top module: `unary_alu`

## Requirements
- R1: Operation code 0 (clear) returns zero and sets flags to N=0 Z=1 V=0 C=0. Flags are packed as {N,Z,V,C} in bits 3..0.
- R2: Code 1 (complement) inverts the active bits. It sets C=1 and V=0, and takes N and Z from the result.
- R3: Code 2 (increment) adds one and sets V only when the operand was the largest positive value. Code 3 (decrement) subtracts one and sets V only when the operand was the most negative value. Both leave C as it came in.
- R4: Code 4 (negate) forms the two's complement, so the most negative value maps to itself. V is set when the result is the most negative value, and C is set for every nonzero result.
- R5: Code 5 (add carry) adds the incoming C. V=1 only for the largest positive operand with C=1. C=1 only for an all-ones operand with C=1.
- R6: Code 6 (subtract carry) subtracts the incoming C. V=1 only for the most negative operand with C=1. C=1 (borrow) only for a zero operand with C=1.
- R7: Code 8 (rotate right) moves the lowest bit into C and the old C into the sign bit. Code 9 (rotate left) moves the sign bit into C and the old C into bit 0. Both set V = N xor C, computed on the new flags.
- R8: Code 10 (arithmetic right shift) keeps the sign bit and moves the lowest bit into C. Code 11 (left shift) fills bit 0 with zero and moves the sign bit into C. Both set V = N xor C after the shift.
- R9: Code 12 (sign extend) returns all ones when the incoming N is set and zero when it is clear. It keeps N and C, sets Z to not N, and clears V.
- R10: Code 13 (byte swap, word mode only) exchanges the two bytes. N and Z come from the low byte of the result, and V=C=0.
- R11: Code 7 (test) returns the operand unchanged, takes N and Z from it, and clears V and C. The store strobe is 0 for test and 1 for every other legal operation.
- R12: With the byte select set, the sign is bit 7, the boundary constants are 8'h7F, 8'h80 and 8'hFF, and the result's upper byte equals the operand's upper byte.
- R13: Byte swap in byte mode, and codes 14 and 15, raise the error output. The result then equals the operand, the flags equal the incoming flags, and the store strobe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, encoded as in the requirements |
| byte_mode | input | 1 | 1 = operate on the low 8 bits only |
| operand | input | 16 | Destination operand value |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 16 | New operand value |
| flags_out | output | 4 | New flags {N,Z,V,C} |
| store_en | output | 1 | Result should be written back |
| op_error | output | 1 | Illegal operation or mode combination |

## Verification
The block holds no state, so a fault in the lane logic shows at the ports in the same evaluation as the stimulus that reaches it. Most mistakes show as a wrong flag bit rather than a wrong value: a carry that is dropped, overflow taken from the wrong sign bit, or Z computed over the full word during a swap. For that reason every directed case compares all four flags. Each boundary operand is applied in both widths, so a lane that uses the wrong sign position or constant fails on the first case that touches it.

// File: rtl/unary_alu_pkg.sv
package unary_alu_pkg;

  typedef enum logic [3:0] {
    OP_CLR  = 4'd0,
    OP_COM  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_NEG  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_TST  = 4'd7,
    OP_ROR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ASR  = 4'd10,
    OP_ASL  = 4'd11,
    OP_SXT  = 4'd12,
    OP_SWAB = 4'd13
  } uop_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/unary_alu_decode.sv
module unary_alu_decode
  import unary_alu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       byte_i,
  output logic       bad_o,
  output logic       store_o
);

  always_comb begin
    bad_o   = (op_i > 4'(OP_SWAB)) || (byte_i && (op_i == 4'(OP_SWAB)));
    store_o = !bad_o && (op_i != 4'(OP_TST));
  end

  // R11: the test operation never requests a write
  always_comb begin
    assert_test_no_store_R11: assert (!(op_i == 4'(OP_TST) && store_o));
  end

endmodule

// File: rtl/unary_alu_lane.sv
module unary_alu_lane
  import unary_alu_pkg::*;
#(
  parameter int LW = 16
) (
  input  uop_t          op_i,
  input  logic [LW-1:0] a_i,
  input  cc_t           f_i,
  output logic [LW-1:0] r_o,
  output cc_t           f_o
);

  localparam int HW = LW / 2;
  localparam logic [LW-1:0] ZERO   = '0;
  localparam logic [LW-1:0] ONES   = '1;
  localparam logic [LW-1:0] UNIT   = {{(LW-1){1'b0}}, 1'b1};
  localparam logic [LW-1:0] MAXPOS = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MINNEG = {1'b1, {(LW-1){1'b0}}};

  logic [LW-1:0] cin_ext;

  always_comb begin
    cin_ext = {{(LW-1){1'b0}}, f_i.c};
    r_o     = a_i;
    f_o     = f_i;
    unique case (op_i)
      OP_CLR: r_o = ZERO;
      OP_COM: r_o = ~a_i;
      OP_INC: r_o = a_i + UNIT;
      OP_DEC: r_o = a_i - UNIT;
      OP_NEG: r_o = ZERO - a_i;
      OP_ADC: r_o = a_i + cin_ext;
      OP_SBC: r_o = a_i - cin_ext;
      OP_TST: r_o = a_i;
      OP_ROR: r_o = {f_i.c, a_i[LW-1:1]};
      OP_ROL: r_o = {a_i[LW-2:0], f_i.c};
      OP_ASR: r_o = {a_i[LW-1], a_i[LW-1:1]};
      OP_ASL: r_o = {a_i[LW-2:0], 1'b0};
      OP_SXT: r_o = f_i.n ? ONES : ZERO;
      OP_SWAB: r_o = {a_i[HW-1:0], a_i[LW-1:HW]};
      default: r_o = a_i;
    endcase

    f_o.n = r_o[LW-1];
    f_o.z = (r_o == ZERO);
    f_o.v = 1'b0;
    f_o.c = 1'b0;
    unique case (op_i)
      OP_CLR, OP_TST: ;
      OP_COM: f_o.c = 1'b1;
      OP_INC: begin f_o.v = (a_i == MAXPOS); f_o.c = f_i.c; end
      OP_DEC: begin f_o.v = (a_i == MINNEG); f_o.c = f_i.c; end
      OP_NEG: begin f_o.v = (r_o == MINNEG); f_o.c = (r_o != ZERO); end
      OP_ADC: begin
        f_o.v = f_i.c && (a_i == MAXPOS);
        f_o.c = f_i.c && (a_i == ONES);
      end
      OP_SBC: begin
        f_o.v = f_i.c && (a_i == MINNEG);
        f_o.c = f_i.c && (a_i == ZERO);
      end
      OP_ROR, OP_ASR: begin f_o.c = a_i[0];    f_o.v = r_o[LW-1] ^ a_i[0]; end
      OP_ROL, OP_ASL: begin f_o.c = a_i[LW-1]; f_o.v = r_o[LW-1] ^ a_i[LW-1]; end
      OP_SXT: begin f_o.n = f_i.n; f_o.z = !f_i.n; f_o.c = f_i.c; end
      OP_SWAB: begin f_o.n = r_o[HW-1]; f_o.z = (r_o[HW-1:0] == '0); end
      default: f_o = f_i;
    endcase
  end

endmodule

// File: rtl/unary_alu.sv
module unary_alu
  import unary_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op_code,
  input  logic             byte_mode,
  input  logic [WIDTH-1:0] operand,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic             store_en,
  output logic             op_error
);

  localparam int HALF = WIDTH / 2;

  uop_t             op;
  cc_t              cc_in;
  logic [WIDTH-1:0] word_r;
  cc_t              word_f;
  logic [HALF-1:0]  byte_r;
  cc_t              byte_f;
  logic             bad;
  logic             store;

  assign op    = uop_t'(op_code);
  assign cc_in = cc_t'(flags_in);

  unary_alu_decode u_dec (
    .op_i    (op_code),
    .byte_i  (byte_mode),
    .bad_o   (bad),
    .store_o (store)
  );

  unary_alu_lane #(.LW(WIDTH)) u_word (
    .op_i (op),
    .a_i  (operand),
    .f_i  (cc_in),
    .r_o  (word_r),
    .f_o  (word_f)
  );

  unary_alu_lane #(.LW(HALF)) u_byte (
    .op_i (op),
    .a_i  (operand[HALF-1:0]),
    .f_i  (cc_in),
    .r_o  (byte_r),
    .f_o  (byte_f)
  );

  always_comb begin
    store_en = store;
    op_error = bad;
    if (bad) begin
      result    = operand;
      flags_out = flags_in;
    end else if (byte_mode) begin
      result    = {operand[WIDTH-1:HALF], byte_r};
      flags_out = byte_f;
    end else begin
      result    = word_r;
      flags_out = word_f;
    end
  end

  always_comb begin
    // R12: upper byte passes through in byte mode
    assert_upper_kept_R12: assert (!(byte_mode && !op_error) ||
                                   (result[WIDTH-1:HALF] == operand[WIDTH-1:HALF]));
    // R13: illegal requests change nothing and store nothing
    assert_error_quiet_R13: assert (!op_error ||
                                    (!store_en && result == operand && flags_out == flags_in));
    // R3: increment and decrement keep the carry
    assert_carry_kept_R3: assert (op_error || !(op == OP_INC || op == OP_DEC) ||
                                  (flags_out[0] == flags_in[0]));
    // R7 and R8: overflow tracks sign xor carry for shifts and rotates
    assert_shift_v_R8: assert (op_error || !(op == OP_ROR || op == OP_ROL ||
                                             op == OP_ASR || op == OP_ASL) ||
                               (flags_out[1] == (flags_out[3] ^ flags_out[0])));
    // R1: clear yields zero lane and only Z set
    assert_clear_R1: assert (op_error || op != OP_CLR ||
                             (result[HALF-1:0] == '0 && flags_out == 4'b0100));
  end

endmodule

// File: tb/unary_alu_test.sv
module unary_alu_test;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_code;
  logic        byte_mode;
  logic [15:0] operand;
  logic [3:0]  flags_in;
  logic [15:0] result;
  logic [3:0]  flags_out;
  logic        store_en;
  logic        op_error;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  unary_alu uut (
    .op_code   (op_code),
    .byte_mode (byte_mode),
    .operand   (operand),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .store_en  (store_en),
    .op_error  (op_error)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply(input logic [3:0] op, input logic bm,
                       input logic [15:0] a, input logic [3:0] f);
    @(negedge clk);
    op_code = op; byte_mode = bm; operand = a; flags_in = f;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [15:0] er,
                            input logic [3:0] ef, input logic ew, input logic ee);
    checks++;
    if (result !== er || flags_out !== ef || store_en !== ew || op_error !== ee) begin
      failures++;
      $display("FAIL %s: got r=%h f=%b we=%b err=%b, expected r=%h f=%b we=%b err=%b",
               req, result, flags_out, store_en, op_error, er, ef, ew, ee);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic bm,
                     input logic [15:0] a, input logic [3:0] f,
                     input logic [15:0] er, input logic [3:0] ef,
                     input logic ew, input logic ee);
    apply(op, bm, a, f);
    expect_out(req, er, ef, ew, ee);
  endtask

  task automatic test_reset_state();
    run("R11 reset", 4'd7, 1'b0, 16'h0000, 4'b0000, 16'h0000, 4'b0100, 1'b0, 1'b0);
  endtask

  task automatic test_clear_complement();
    run("R1 clear", 4'd0, 1'b0, 16'h1234, 4'b1111, 16'h0000, 4'b0100, 1'b1, 1'b0);
    run("R2 com", 4'd1, 1'b0, 16'h00FF, 4'b0000, 16'hFF00, 4'b1001, 1'b1, 1'b0);
    run("R2 com zero", 4'd1, 1'b0, 16'hFFFF, 4'b0010, 16'h0000, 4'b0101, 1'b1, 1'b0);
  endtask

  task automatic test_inc_dec();
    run("R3 inc max", 4'd2, 1'b0, 16'h7FFF, 4'b0001, 16'h8000, 4'b1011, 1'b1, 1'b0);
    run("R3 inc wrap", 4'd2, 1'b0, 16'hFFFF, 4'b0000, 16'h0000, 4'b0100, 1'b1, 1'b0);
    run("R3 dec min", 4'd3, 1'b0, 16'h8000, 4'b0000, 16'h7FFF, 4'b0010, 1'b1, 1'b0);
    run("R3 dec one", 4'd3, 1'b0, 16'h0001, 4'b0001, 16'h0000, 4'b0101, 1'b1, 1'b0);
  endtask

  task automatic test_negate();
    run("R4 neg min", 4'd4, 1'b0, 16'h8000, 4'b0000, 16'h8000, 4'b1011, 1'b1, 1'b0);
    run("R4 neg zero", 4'd4, 1'b0, 16'h0000, 4'b0001, 16'h0000, 4'b0100, 1'b1, 1'b0);
    run("R4 neg five", 4'd4, 1'b0, 16'h0005, 4'b0000, 16'hFFFB, 4'b1001, 1'b1, 1'b0);
  endtask

  task automatic test_carry_ops();
    run("R5 adc max", 4'd5, 1'b0, 16'h7FFF, 4'b0001, 16'h8000, 4'b1010, 1'b1, 1'b0);
    run("R5 adc ones", 4'd5, 1'b0, 16'hFFFF, 4'b0001, 16'h0000, 4'b0101, 1'b1, 1'b0);
    run("R5 adc noc", 4'd5, 1'b0, 16'h1234, 4'b0000, 16'h1234, 4'b0000, 1'b1, 1'b0);
    run("R6 sbc min", 4'd6, 1'b0, 16'h8000, 4'b0001, 16'h7FFF, 4'b0010, 1'b1, 1'b0);
    run("R6 sbc zero", 4'd6, 1'b0, 16'h0000, 4'b0001, 16'hFFFF, 4'b1001, 1'b1, 1'b0);
  endtask

  task automatic test_rotate_shift();
    run("R7 ror", 4'd8, 1'b0, 16'h0001, 4'b0000, 16'h0000, 4'b0111, 1'b1, 1'b0);
    run("R7 rol", 4'd9, 1'b0, 16'h8000, 4'b0001, 16'h0001, 4'b0011, 1'b1, 1'b0);
    run("R8 asr", 4'd10, 1'b0, 16'h8001, 4'b0000, 16'hC000, 4'b1001, 1'b1, 1'b0);
    run("R8 asl", 4'd11, 1'b0, 16'h4000, 4'b0001, 16'h8000, 4'b1010, 1'b1, 1'b0);
  endtask

  task automatic test_sxt_swab_tst();
    run("R9 sxt neg", 4'd12, 1'b0, 16'h1234, 4'b1000, 16'hFFFF, 4'b1000, 1'b1, 1'b0);
    run("R9 sxt pos", 4'd12, 1'b0, 16'h1234, 4'b0111, 16'h0000, 4'b0101, 1'b1, 1'b0);
    run("R10 swab", 4'd13, 1'b0, 16'h1280, 4'b1111, 16'h8012, 4'b0000, 1'b1, 1'b0);
    run("R10 swab lowz", 4'd13, 1'b0, 16'h0080, 4'b1111, 16'h8000, 4'b0100, 1'b1, 1'b0);
    run("R11 tst", 4'd7, 1'b0, 16'h8000, 4'b0111, 16'h8000, 4'b1000, 1'b0, 1'b0);
  endtask

  task automatic test_byte_mode();
    run("R12 inc b", 4'd2, 1'b1, 16'hAB7F, 4'b0000, 16'hAB80, 4'b1010, 1'b1, 1'b0);
    run("R12 neg b", 4'd4, 1'b1, 16'h5580, 4'b0000, 16'h5580, 4'b1011, 1'b1, 1'b0);
    run("R12 com b", 4'd1, 1'b1, 16'h12FF, 4'b0000, 16'h1200, 4'b0101, 1'b1, 1'b0);
    run("R12 adc b", 4'd5, 1'b1, 16'h34FF, 4'b0001, 16'h3400, 4'b0101, 1'b1, 1'b0);
    run("R12 ror b", 4'd8, 1'b1, 16'hFF01, 4'b0001, 16'hFF80, 4'b1001, 1'b1, 1'b0);
    run("R12 clr b", 4'd0, 1'b1, 16'hBEEF, 4'b1011, 16'hBE00, 4'b0100, 1'b1, 1'b0);
  endtask

  task automatic test_illegal();
    run("R13 swab b", 4'd13, 1'b1, 16'h1234, 4'b1010, 16'h1234, 4'b1010, 1'b0, 1'b1);
    run("R13 code14", 4'd14, 1'b0, 16'h8001, 4'b0101, 16'h8001, 4'b0101, 1'b0, 1'b1);
    run("R13 code15", 4'd15, 1'b1, 16'h00FF, 4'b1111, 16'h00FF, 4'b1111, 1'b0, 1'b1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_code = 4'd7; byte_mode = 1'b0; operand = 16'h0000; flags_in = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset_state();
    test_clear_complement();
    test_inc_dec();
    test_negate();
    test_carry_ops();
    test_rotate_shift();
    test_sxt_swab_tst();
    test_byte_mode();
    test_illegal();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule